// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 18-bit words. Its write side and read side run on separate, unrelated clocks. Each side has an active-low enable. Both pointers cross into the other clock domain in Gray code through two-stage synchronizers. The read side sees the write pointer through its synchronizer, and the write side sees the read pointer through its own.

The block has five active-low status outputs: empty, full, half-full, almost-empty and almost-full. The two almost thresholds are kept in an offset register. That register is written and read back through the normal data ports while the active-low load input is held low. A mode input chooses how the almost flags are formed: either registered in their own clock domain, or decoded combinationally from the live pointers of both sides.

A retransmit strobe on the read side rewinds the read pointer, so that data written since reset can be read a second time. The output-drive control is modelled as an enable output.

Top module: `pf_fifo_dc`

## Requirements
- R1: A rising `wclk` edge stores `din` into the next free location only when `wr_en_n`=0, `load_n`=1 and `full_n`=1. A write attempted while full leaves the stored words and the write pointer unchanged.
- R2: A rising `rclk` edge with `rd_en_n`=0, `load_n`=1, `retx_n`=1 and `empty_n`=1 registers the oldest unread word onto `dout`, in write order. A read attempted while empty leaves `dout` and the read pointer unchanged.
- R3: `empty_n` is 0 exactly when the read-side occupancy is zero. `full_n` is 0 exactly when the write-side occupancy equals DEPTH.
- R4: `half_n` is 0 exactly when the write-side occupancy is at least DEPTH/2.
- R5: `aempty_n` is 0 when occupancy is at most the almost-empty offset. `afull_n` is 0 when occupancy is at least DEPTH minus the almost-full offset.
- R6: With `async_flags`=0, the almost flags come from registers in their own clock domain. With `async_flags`=1, they are decoded combinationally from both live pointers. In both modes the flags take the same values once the pointers are stable.
- R7: While `load_n`=0, a `wclk` edge with `wr_en_n`=0 stores `din[log2(DEPTH)-1:0]` into the offset register. Successive stores go to the almost-empty offset first, then the almost-full offset, alternating. The data memory and the write pointer are not touched.
- R8: While `load_n`=0, an `rclk` edge with `rd_en_n`=0 places one offset, zero-extended, on `dout`. Successive reads return the almost-empty offset first, then the almost-full offset, alternating. The read pointer is not touched.
- R9: Reset (`rst_n`=0, asynchronous) has these effects:
  - the buffer becomes empty;
  - `dout` is cleared to 0;
  - both offsets are set to 7;
  - both alternation selectors return to the almost-empty offset.
- R10: An `rclk` edge with `retx_n`=0 moves the read pointer back to location 0, ahead of any read. The flags are then recomputed from the restored pointer. This replays every word written since reset, as long as fewer than DEPTH words have been written since reset.
- R11: `dout_en` is 1 while `oe_n` is 0 and 0 while `oe_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| load_n | input | 1 | Active-low offset-register access select |
| retx_n | input | 1 | Active-low retransmit strobe (read clock) |
| async_flags | input | 1 | 1 = combinational almost flags, 0 = registered |
| oe_n | input | 1 | Active-low output drive request |
| din | input | 18 | Write data or offset value |
| dout | output | 18 | Read data or offset readback |
| dout_en | output | 1 | Output drive enable |
| empty_n | output | 1 | Empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| half_n | output | 1 | Half-full flag, active low, write domain |
| aempty_n | output | 1 | Almost-empty flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |

## Verification
The bench builds the block with DEPTH=16. At that depth, every occupancy from 0 to full, and every threshold crossing for the reset offsets and for the reloaded ones, can be stepped through one word at a time, in both flag modes. The small depth also lets the pointers wrap several times within a short run. A later reset brings a retransmit of a partly written buffer within reach.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int DATA_W       = 18;
    localparam int OFFSET_RESET = 7;

    typedef enum logic {
        SEL_EMPTY_SIDE = 1'b0,
        SEL_FULL_SIDE  = 1'b1
    } off_sel_e;
endpackage

// File: rtl/pf_gray_sync.sv
// Two-stage synchronizer for a Gray-coded pointer, with binary output.
module pf_gray_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;
    logic [W-1:0] bin_c;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = gray_in;
        sync_d.s2 = sync_q.s1;
        bin_c[W-1] = sync_q.s2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_c[i] = bin_c[i+1] ^ sync_q.s2[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign bin_out = bin_c;
endmodule

// File: rtl/pf_wr_ctl.sv
// Write-side control: pointer, offset register, full/half/almost-full flags.
module pf_wr_ctl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          load_n,
    input  logic          async_flags,
    input  logic [AW-1:0] off_in,
    input  logic [AW:0]   rptr_sync_bin,
    input  logic [AW:0]   rptr_live_bin,
    output logic [AW:0]   wptr_bin,
    output logic [AW:0]   wptr_gray,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off,
    output logic          full_n,
    output logic          half_n,
    output logic          afull_n
);
    import pf_pkg::*;

    localparam int        DEPTH  = 1 << AW;
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_V  = (AW+1)'(DEPTH / 2);

    typedef struct packed {
        logic [AW:0]   bin;
        logic [AW:0]   gray;
        logic [AW-1:0] ae_off;
        logic [AW-1:0] af_off;
        off_sel_e      sel;
        logic          afull;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [AW:0] occ_q, occ_d, occ_live;
    logic        is_full, afull_live;

    always_comb begin
        st_d    = st_q;
        mem_we  = 1'b0;
        occ_q   = st_q.bin - rptr_sync_bin;
        is_full = (occ_q == DEPTH_V);
        if (!wr_en_n) begin
            if (!load_n) begin
                if (st_q.sel == SEL_EMPTY_SIDE) st_d.ae_off = off_in;
                else                            st_d.af_off = off_in;
                st_d.sel = (st_q.sel == SEL_EMPTY_SIDE) ? SEL_FULL_SIDE : SEL_EMPTY_SIDE;
            end else if (!is_full) begin
                mem_we   = 1'b1;
                st_d.bin = st_q.bin + 1'b1;
            end
        end
        st_d.gray  = st_d.bin ^ (st_d.bin >> 1);
        occ_d      = st_d.bin - rptr_sync_bin;
        st_d.afull = (occ_d >= (DEPTH_V - {1'b0, st_d.af_off}));
        occ_live   = st_q.bin - rptr_live_bin;
        afull_live = (occ_live >= (DEPTH_V - {1'b0, st_q.af_off}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bin    <= '0;
            st_q.gray   <= '0;
            st_q.ae_off <= AW'(OFFSET_RESET);
            st_q.af_off <= AW'(OFFSET_RESET);
            st_q.sel    <= SEL_EMPTY_SIDE;
            st_q.afull  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr_bin  = st_q.bin;
    assign wptr_gray = st_q.gray;
    assign mem_addr  = st_q.bin[AW-1:0];
    assign ae_off    = st_q.ae_off;
    assign af_off    = st_q.af_off;
    assign full_n    = !is_full;
    assign half_n    = !(occ_q >= HALF_V);
    assign afull_n   = async_flags ? !afull_live : !st_q.afull;
endmodule

// File: rtl/pf_rd_ctl.sv
// Read-side control: pointer, retransmit, output register, empty/almost-empty flags.
module pf_rd_ctl #(
    parameter int AW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en_n,
    input  logic                      load_n,
    input  logic                      retx_n,
    input  logic                      async_flags,
    input  logic [AW:0]               wptr_sync_bin,
    input  logic [AW:0]               wptr_live_bin,
    input  logic [AW-1:0]             ae_off,
    input  logic [AW-1:0]             af_off,
    input  logic [pf_pkg::DATA_W-1:0] mem_rdata,
    output logic [AW:0]               rptr_bin,
    output logic [AW:0]               rptr_gray,
    output logic [AW-1:0]             mem_addr,
    output logic [pf_pkg::DATA_W-1:0] dout,
    output logic                      empty_n,
    output logic                      aempty_n
);
    import pf_pkg::*;

    localparam int PAD_W = DATA_W - AW;

    typedef struct packed {
        logic [AW:0]       bin;
        logic [AW:0]       gray;
        logic [DATA_W-1:0] dout;
        off_sel_e          sel;
        logic              aempty;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [AW:0] occ_q, occ_d, occ_live;
    logic        is_empty, aempty_live;

    always_comb begin
        st_d     = st_q;
        occ_q    = wptr_sync_bin - st_q.bin;
        is_empty = (occ_q == '0);
        if (!retx_n) begin
            st_d.bin = '0;
        end else if (!rd_en_n) begin
            if (!load_n) begin
                st_d.dout = (st_q.sel == SEL_EMPTY_SIDE) ? {{PAD_W{1'b0}}, ae_off}
                                                         : {{PAD_W{1'b0}}, af_off};
                st_d.sel  = (st_q.sel == SEL_EMPTY_SIDE) ? SEL_FULL_SIDE : SEL_EMPTY_SIDE;
            end else if (!is_empty) begin
                st_d.dout = mem_rdata;
                st_d.bin  = st_q.bin + 1'b1;
            end
        end
        st_d.gray   = st_d.bin ^ (st_d.bin >> 1);
        occ_d       = wptr_sync_bin - st_d.bin;
        st_d.aempty = (occ_d <= {1'b0, ae_off});
        occ_live    = wptr_live_bin - st_q.bin;
        aempty_live = (occ_live <= {1'b0, ae_off});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bin    <= '0;
            st_q.gray   <= '0;
            st_q.dout   <= '0;
            st_q.sel    <= SEL_EMPTY_SIDE;
            st_q.aempty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rptr_bin  = st_q.bin;
    assign rptr_gray = st_q.gray;
    assign mem_addr  = st_q.bin[AW-1:0];
    assign dout      = st_q.dout;
    assign empty_n   = !is_empty;
    assign aempty_n  = async_flags ? !aempty_live : !st_q.aempty;
endmodule

// File: rtl/pf_fifo_dc.sv
// Top: dual-clock FIFO with programmable almost flags.
module pf_fifo_dc #(
    parameter int DEPTH = 256
) (
    input  logic                      wclk,
    input  logic                      rclk,
    input  logic                      rst_n,
    input  logic                      wr_en_n,
    input  logic                      rd_en_n,
    input  logic                      load_n,
    input  logic                      retx_n,
    input  logic                      async_flags,
    input  logic                      oe_n,
    input  logic [pf_pkg::DATA_W-1:0] din,
    output logic [pf_pkg::DATA_W-1:0] dout,
    output logic                      dout_en,
    output logic                      empty_n,
    output logic                      full_n,
    output logic                      half_n,
    output logic                      aempty_n,
    output logic                      afull_n
);
    import pf_pkg::*;

    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    logic [AW-1:0]     w_addr, r_addr;
    logic [AW:0]       w_bin, w_gray, r_bin, r_gray;
    logic [AW:0]       w_bin_at_r, r_bin_at_w;
    logic [AW-1:0]     ae_off, af_off;

    always_ff @(posedge wclk) begin
        if (mem_we) mem[w_addr] <= din;
    end
    assign mem_rdata = mem[r_addr];

    pf_wr_ctl #(.AW(AW)) u_wr (
        .clk           (wclk),
        .rst_n         (rst_n),
        .wr_en_n       (wr_en_n),
        .load_n        (load_n),
        .async_flags   (async_flags),
        .off_in        (din[AW-1:0]),
        .rptr_sync_bin (r_bin_at_w),
        .rptr_live_bin (r_bin),
        .wptr_bin      (w_bin),
        .wptr_gray     (w_gray),
        .mem_we        (mem_we),
        .mem_addr      (w_addr),
        .ae_off        (ae_off),
        .af_off        (af_off),
        .full_n        (full_n),
        .half_n        (half_n),
        .afull_n       (afull_n)
    );

    pf_rd_ctl #(.AW(AW)) u_rd (
        .clk           (rclk),
        .rst_n         (rst_n),
        .rd_en_n       (rd_en_n),
        .load_n        (load_n),
        .retx_n        (retx_n),
        .async_flags   (async_flags),
        .wptr_sync_bin (w_bin_at_r),
        .wptr_live_bin (w_bin),
        .ae_off        (ae_off),
        .af_off        (af_off),
        .mem_rdata     (mem_rdata),
        .rptr_bin      (r_bin),
        .rptr_gray     (r_gray),
        .mem_addr      (r_addr),
        .dout          (dout),
        .empty_n       (empty_n),
        .aempty_n      (aempty_n)
    );

    pf_gray_sync #(.W(AW + 1)) u_w2r (
        .clk     (rclk),
        .rst_n   (rst_n),
        .gray_in (w_gray),
        .bin_out (w_bin_at_r)
    );

    pf_gray_sync #(.W(AW + 1)) u_r2w (
        .clk     (wclk),
        .rst_n   (rst_n),
        .gray_in (r_gray),
        .bin_out (r_bin_at_w)
    );

    assign dout_en = !oe_n;
endmodule

// File: rtl/pf_fifo_dc_chk.sv
// Property checker attached to the top module.
module pf_fifo_dc_chk #(
    parameter int AW = 8
) (
    input logic                      wclk,
    input logic                      rclk,
    input logic                      rst_n,
    input logic                      wr_en_n,
    input logic                      rd_en_n,
    input logic                      load_n,
    input logic                      retx_n,
    input logic                      empty_n,
    input logic                      full_n,
    input logic                      half_n,
    input logic [AW:0]               wptr,
    input logic [AW:0]               rptr,
    input logic [pf_pkg::DATA_W-1:0] dout
);
    // R1
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && !wr_en_n && load_n) |=> $stable(wptr));

    // R1
    wr_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> ((wptr == $past(wptr)) || (wptr == $past(wptr) + 1'b1)));

    // R2
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && !rd_en_n && load_n && retx_n) |=> ($stable(rptr) && $stable(dout)));

    // R4
    full_half_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !half_n);

    // R7
    load_wr_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !load_n |=> $stable(wptr));

    // R8
    load_rd_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!load_n && retx_n) |=> $stable(rptr));

    // R10
    retx_rewind_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !retx_n |=> (rptr == '0));
endmodule

bind pf_fifo_dc pf_fifo_dc_chk #(.AW(AW)) u_chk (
    .wclk    (wclk),
    .rclk    (rclk),
    .rst_n   (rst_n),
    .wr_en_n (wr_en_n),
    .rd_en_n (rd_en_n),
    .load_n  (load_n),
    .retx_n  (retx_n),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n),
    .wptr    (w_bin),
    .rptr    (r_bin),
    .dout    (dout)
);

// File: tb/sim_pf_fifo_dc.sv
module sim_pf_fifo_dc;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DEPTH       = 16;

    logic        wclk = 1'b0, rclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_n = 1'b1, rd_en_n = 1'b1, load_n = 1'b1, retx_n = 1'b1;
    logic        async_flags = 1'b0, oe_n = 1'b1;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic        dout_en, empty_n, full_n, half_n, aempty_n, afull_n;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    pf_fifo_dc #(.DEPTH(DEPTH)) u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .load_n(load_n), .retx_n(retx_n),
        .async_flags(async_flags), .oe_n(oe_n), .din(din), .dout(dout),
        .dout_en(dout_en), .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
        .aempty_n(aempty_n), .afull_n(afull_n)
    );

    function automatic logic [17:0] pat(input int n);
        return 18'((n * 1237 + 5) & 32'h3FFFF);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_flags(input int occ, input int ae, input int af, input string tag);
        check({tag, " R3 empty_n"}, 32'(empty_n), 32'(occ != 0));
        check({tag, " R3 full_n"}, 32'(full_n), 32'(occ != DEPTH));
        check({tag, " R4 half_n"}, 32'(half_n), 32'(!(occ >= DEPTH / 2)));
        check({tag, " R5 aempty_n"}, 32'(aempty_n), 32'(!(occ <= ae)));
        check({tag, " R5 afull_n"}, 32'(afull_n), 32'(!(occ >= DEPTH - af)));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge wclk);
        rst_n = 1'b1;
        repeat (3) @(negedge rclk);
    endtask

    task automatic wr_word(input logic [17:0] d);
        @(negedge wclk);
        din = d;
        wr_en_n = 1'b0;
        @(negedge wclk);
        wr_en_n = 1'b1;
    endtask

    task automatic rd_word();
        @(negedge rclk);
        rd_en_n = 1'b0;
        @(negedge rclk);
        rd_en_n = 1'b1;
    endtask

    task automatic settle();
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R9 reset state
        check("R9 dout after reset", 32'(dout), 32'h0);
        check_flags(0, 7, 7, "R9 reset");

        // R11 output enable
        oe_n = 1'b0; #1;
        check("R11 dout_en low oe_n", 32'(dout_en), 32'h1);
        oe_n = 1'b1; #1;
        check("R11 dout_en high oe_n", 32'(dout_en), 32'h0);

        // R1/R3/R4/R5: fill sweep, registered flags
        for (int n = 1; n <= DEPTH; n++) begin
            wr_word(pat(n));
            settle();
            check_flags(n, 7, 7, "R1 fill sync");
        end
        // R1 write while full is ignored
        wr_word(18'h3FFFF);
        settle();
        check_flags(DEPTH, 7, 7, "R1 overfull");

        // R2 drain in order
        for (int n = 1; n <= DEPTH; n++) begin
            rd_word();
            check("R2 read data", 32'(dout), 32'(pat(n)));
            settle();
            check_flags(DEPTH - n, 7, 7, "R2 drain sync");
        end
        // R2 read while empty leaves dout
        rd_word();
        check("R2 empty read dout", 32'(dout), 32'(pat(DEPTH)));
        settle();
        check_flags(0, 7, 7, "R2 empty read");

        // R7 load offsets: AE=3 then AF=5, memory untouched
        load_n = 1'b0;
        wr_word(18'h3FFF3);
        wr_word(18'h00005);
        load_n = 1'b1;
        settle();
        check("R7 load keeps empty", 32'(empty_n), 32'h0);

        // R6/R5: combinational flags with new offsets
        async_flags = 1'b1;
        for (int n = 1; n <= DEPTH; n++) begin
            wr_word(pat(n + 40));
            settle();
            check_flags(n, 3, 5, "R6 fill async");
        end

        // R8 offset readback, pointer untouched
        load_n = 1'b0;
        rd_word();
        check("R8 readback ae", 32'(dout), 32'h3);
        rd_word();
        check("R8 readback af", 32'(dout), 32'h5);
        load_n = 1'b1;
        settle();
        check_flags(DEPTH, 3, 5, "R8 after readback");

        for (int n = 1; n <= DEPTH; n++) begin
            rd_word();
            check("R8 R2 read data after readback", 32'(dout), 32'(pat(n + 40)));
            settle();
            check_flags(DEPTH - n, 3, 5, "R6 drain async");
        end

        // R6: registered mode with loaded offsets
        async_flags = 1'b0;
        for (int n = 1; n <= 6; n++) begin
            wr_word(pat(n + 80));
            settle();
            check_flags(n, 3, 5, "R6 refill sync");
        end

        // R9 reset restores offsets to 7
        do_reset();
        check_flags(0, 7, 7, "R9 second reset");
        load_n = 1'b0;
        rd_word();
        check("R9 ae offset reset", 32'(dout), 32'h7);
        rd_word();
        check("R9 af offset reset", 32'(dout), 32'h7);
        load_n = 1'b1;

        // R10 retransmit
        for (int k = 1; k <= 5; k++) wr_word(pat(k + 200));
        settle();
        for (int k = 1; k <= 5; k++) begin
            rd_word();
            check("R10 first pass", 32'(dout), 32'(pat(k + 200)));
        end
        settle();
        check_flags(0, 7, 7, "R10 before rewind");
        @(negedge rclk);
        retx_n = 1'b0;
        @(negedge rclk);
        retx_n = 1'b1;
        settle();
        check_flags(5, 7, 7, "R10 after rewind");
        for (int k = 1; k <= 5; k++) begin
            rd_word();
            check("R10 replay", 32'(dout), 32'(pat(k + 200)));
        end
        settle();
        check_flags(0, 7, 7, "R10 replay done");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule